// File: doc/BRIEF.md
# Shared-RAM Mailbox Access Port

This block is the host-side window into a small byte-wide RAM that the host shares with an I/O coprocessor. The host sees four byte registers selected by a 2-bit register index. Two of them load a 16-bit RAM pointer, one byte each. A data register reads or writes the RAM byte under that pointer and can step the pointer after each access, so a whole block can be streamed through one register. The fourth register is a combined status/control byte. It carries the coprocessor run control, the auto-increment enable, a pass-through (bypass) mode bit and a doorbell that interrupts the coprocessor. It also holds two host interrupt flags that the coprocessor raises, INT0 and INT1, which share one host interrupt line.

The coprocessor has its own simple port. It reads and writes the same RAM with a combinational read path, raises INT0 or INT1 with one-cycle pulses, and clears the doorbell with an acknowledge pulse. Host register reads are combinational. Every register update, pointer step and RAM write takes effect at the next rising clock edge. If the host and the coprocessor write the same RAM byte in the same cycle, the coprocessor's value is the one stored.

Run control is a two-state machine. CORE_HALT is the reset state and holds `cp_run` low. The transition HALT_TO_RUN happens on a status write with the run bit set. CORE_RUN drives `cp_run` high. The transition RUN_TO_HALT happens on a status write with the run bit clear. Any other cycle keeps the current state.

Top module: `mbox_port`

## Requirements
- R1: After reset, the status register reads 0x00, both pointer bytes read 0x00, and `host_irq`, `cp_run`, `cp_bypass` and `cp_doorbell` are all low.
- R2: A write to register 0 loads pointer bits 7:0 and a write to register 1 loads pointer bits 15:8. Reading those registers returns the pointer bytes, and the read does not change the pointer.
- R3: A write to register 2 stores the byte in the RAM at the low MEM_AW pointer bits, and a read of register 2 returns that byte. The coprocessor port reads and writes the same storage, so a byte written on one side is visible on the other (for example, a health byte set to 0xFF by the coprocessor and cleared to 0 by the host).
- R4: When status bit 0 (auto-increment) is 1, each read or write of register 2 advances the pointer by one at the end of the access. When bit 0 is 0, the pointer stays where it is.
- R5: Auto-increment from 0xFFFF gives 0x0000.
- R6: Writing status bit 2 as 1 raises `cp_doorbell` from the next cycle on. It stays high until a `cp_db_ack` pulse. Writing bit 2 as 0 has no effect on it.
- R7: A `cp_set_int0` pulse sets status bit 4 and a `cp_set_int1` pulse sets status bit 5. `host_irq` is high while either bit is set.
- R8: Status bits 4 and 5 are write-one-to-clear. Clearing one bit leaves the other pending. Writing 0 in a flag position leaves that flag unchanged.
- R9: When the coprocessor sets a flag in the same cycle as a host clear of that flag, the flag ends up set.
- R10: Status bit 1 is the run control. A status write moves the state machine to CORE_RUN when the bit is 1 and to CORE_HALT when it is 0. `cp_run` is high in CORE_RUN, and the bit reads back as the state.
- R11: Status bit 7 is the bypass bit and drives `cp_bypass`. Writing 0x87 sets bypass, run, auto-increment and the doorbell, and the status then reads 0x87. Status bits 3 and 6 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_sel | input | 1 | Host register access select |
| h_wr | input | 1 | Host write strobe (takes priority over h_rd) |
| h_rd | input | 1 | Host read strobe (drives the auto-increment on data reads) |
| h_reg | input | 2 | Register index: 0 pointer low, 1 pointer high, 2 data, 3 status/control |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data for the selected register (combinational) |
| host_irq | output | 1 | Host interrupt, high while INT0 or INT1 is pending |
| cp_en | input | 1 | Coprocessor RAM access enable |
| cp_we | input | 1 | Coprocessor RAM write enable |
| cp_addr | input | MEM_AW | Coprocessor RAM address |
| cp_wdata | input | 8 | Coprocessor RAM write data |
| cp_rdata | output | 8 | Coprocessor RAM read data (combinational) |
| cp_set_int0 | input | 1 | Pulse that sets the INT0 flag |
| cp_set_int1 | input | 1 | Pulse that sets the INT1 flag |
| cp_db_ack | input | 1 | Pulse that clears the doorbell |
| cp_run | output | 1 | Coprocessor run enable |
| cp_bypass | output | 1 | Pass-through mode for the coprocessor's peripherals |
| cp_doorbell | output | 1 | Interrupt request toward the coprocessor |

## Verification
The bench builds the block with MEM_AW = 6, a 64-byte RAM. The full 16-bit pointer stays in place, so the pointer at 0xFFFF selects the top RAM byte 63. That setting lets the bench cover the pointer wrap and the RAM's top byte in a single write, and it can check the result from the coprocessor side. The small depth also keeps the streaming and health-byte exchanges short while still using pointer values whose high byte is nonzero.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int BYTE_W = 8;

    // register index values
    localparam int REG_PTR_LO = 0;
    localparam int REG_PTR_HI = 1;
    localparam int REG_DATA   = 2;
    localparam int REG_CTRL   = 3;

    // status/control bit positions
    localparam int BIT_AUTOINC  = 0;
    localparam int BIT_RUN      = 1;
    localparam int BIT_DOORBELL = 2;
    localparam int BIT_INT0     = 4;
    localparam int BIT_INT1     = 5;
    localparam int BIT_BYPASS   = 7;

    typedef enum logic {
        CORE_HALT = 1'b0,
        CORE_RUN  = 1'b1
    } core_state_t;
endpackage

// File: rtl/mbox_ptr.sv
module mbox_ptr #(
    parameter int BYTE_W = 8,
    parameter int PTR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step,
    output logic [PTR_W-1:0]  ptr
);
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (ld_lo)
            ptr_d[BYTE_W-1:0] = wdata;
        else if (ld_hi)
            ptr_d[PTR_W-1:BYTE_W] = wdata[PTR_W-BYTE_W-1:0];
        else if (step)
            ptr_d = ptr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R4 / R5: a step advances by one, wrapping at the top
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_lo && !ld_hi) |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)));

    // R4: without a load or step the pointer holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld_lo && !ld_hi) |=> $stable(ptr_q));
endmodule

// File: rtl/mbox_ram.sv
module mbox_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] h_addr,
    input  logic          h_we,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic          cp_en,
    input  logic          cp_we,
    input  logic [AW-1:0] cp_addr,
    input  logic [DW-1:0] cp_wdata,
    output logic [DW-1:0] cp_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // coprocessor write is placed last so it wins on a same-byte collision
    always_ff @(posedge clk) begin
        if (h_we)
            mem[h_addr] <= h_wdata;
        if (cp_en && cp_we)
            mem[cp_addr] <= cp_wdata;
    end

    assign h_rdata  = mem[h_addr];
    assign cp_rdata = mem[cp_addr];
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              cp_set_int0,
    input  logic              cp_set_int1,
    input  logic              cp_db_ack,
    output logic [BYTE_W-1:0] status,
    output logic              autoinc,
    output logic              cp_run,
    output logic              cp_bypass,
    output logic              cp_doorbell,
    output logic              host_irq
);
    core_state_t state_q, state_d;
    logic autoinc_q, bypass_q, doorbell_q, int0_q, int1_q;

    // next-state logic: HALT_TO_RUN and RUN_TO_HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CORE_HALT: if (wr && wdata[BIT_RUN])  state_d = CORE_RUN;
            CORE_RUN:  if (wr && !wdata[BIT_RUN]) state_d = CORE_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CORE_HALT;
        else        state_q <= state_d;
    end

    // control and flag bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            autoinc_q  <= 1'b0;
            bypass_q   <= 1'b0;
            doorbell_q <= 1'b0;
            int0_q     <= 1'b0;
            int1_q     <= 1'b0;
        end else begin
            if (wr) begin
                autoinc_q <= wdata[BIT_AUTOINC];
                bypass_q  <= wdata[BIT_BYPASS];
            end
            doorbell_q <= (wr && wdata[BIT_DOORBELL]) || (doorbell_q && !cp_db_ack);
            int0_q     <= cp_set_int0 || (int0_q && !(wr && wdata[BIT_INT0]));
            int1_q     <= cp_set_int1 || (int1_q && !(wr && wdata[BIT_INT1]));
        end
    end

    // outputs
    always_comb begin
        status               = '0;
        status[BIT_AUTOINC]  = autoinc_q;
        status[BIT_RUN]      = (state_q == CORE_RUN);
        status[BIT_DOORBELL] = doorbell_q;
        status[BIT_INT0]     = int0_q;
        status[BIT_INT1]     = int1_q;
        status[BIT_BYPASS]   = bypass_q;
        autoinc              = autoinc_q;
        cp_run               = (state_q == CORE_RUN);
        cp_bypass            = bypass_q;
        cp_doorbell          = doorbell_q;
        host_irq             = int0_q || int1_q;
    end

    // R9: a coprocessor set always lands
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cp_set_int0 |=> int0_q);
    p_set_wins_int1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cp_set_int1 |=> int1_q);

    // R8: a one clears, an unwritten flag stays pending
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[BIT_INT0] && !cp_set_int0) |=> !int0_q);
    p_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int1_q && !(wr && wdata[BIT_INT1])) |=> int1_q);

    // R6: doorbell holds until acknowledged
    p_doorbell_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (doorbell_q && !cp_db_ack) |=> doorbell_q);

    // R10: run state follows the written run bit
    p_run_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cp_run == $past(wdata[BIT_RUN])));
endmodule

// File: rtl/mbox_port.sv
module mbox_port
    import mbox_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_sel,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [1:0]        h_reg,
    input  logic [7:0]        h_wdata,
    output logic [7:0]        h_rdata,
    output logic              host_irq,
    input  logic              cp_en,
    input  logic              cp_we,
    input  logic [MEM_AW-1:0] cp_addr,
    input  logic [7:0]        cp_wdata,
    output logic [7:0]        cp_rdata,
    input  logic              cp_set_int0,
    input  logic              cp_set_int1,
    input  logic              cp_db_ack,
    output logic              cp_run,
    output logic              cp_bypass,
    output logic              cp_doorbell
);
    localparam int PTR_W = 2 * BYTE_W;

    logic              wr_any, rd_any;
    logic              wr_lo, wr_hi, wr_data, wr_ctrl, rd_data;
    logic              autoinc;
    logic              step;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] ram_q, status;

    assign wr_any  = h_sel && h_wr;
    assign rd_any  = h_sel && h_rd && !h_wr;
    assign wr_lo   = wr_any && (h_reg == 2'(REG_PTR_LO));
    assign wr_hi   = wr_any && (h_reg == 2'(REG_PTR_HI));
    assign wr_data = wr_any && (h_reg == 2'(REG_DATA));
    assign wr_ctrl = wr_any && (h_reg == 2'(REG_CTRL));
    assign rd_data = rd_any && (h_reg == 2'(REG_DATA));
    assign step    = autoinc && (wr_data || rd_data);

    mbox_ptr #(.BYTE_W(BYTE_W), .PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (wr_lo),
        .ld_hi (wr_hi),
        .wdata (h_wdata),
        .step  (step),
        .ptr   (ptr)
    );

    mbox_ram #(.AW(MEM_AW), .DW(BYTE_W)) u_ram (
        .clk      (clk),
        .h_addr   (ptr[MEM_AW-1:0]),
        .h_we     (wr_data),
        .h_wdata  (h_wdata),
        .h_rdata  (ram_q),
        .cp_en    (cp_en),
        .cp_we    (cp_we),
        .cp_addr  (cp_addr),
        .cp_wdata (cp_wdata),
        .cp_rdata (cp_rdata)
    );

    mbox_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (wr_ctrl),
        .wdata       (h_wdata),
        .cp_set_int0 (cp_set_int0),
        .cp_set_int1 (cp_set_int1),
        .cp_db_ack   (cp_db_ack),
        .status      (status),
        .autoinc     (autoinc),
        .cp_run      (cp_run),
        .cp_bypass   (cp_bypass),
        .cp_doorbell (cp_doorbell),
        .host_irq    (host_irq)
    );

    always_comb begin
        case (h_reg)
            2'(REG_PTR_LO): h_rdata = ptr[BYTE_W-1:0];
            2'(REG_PTR_HI): h_rdata = ptr[PTR_W-1:BYTE_W];
            2'(REG_DATA):   h_rdata = ram_q;
            default:        h_rdata = status;
        endcase
    end
endmodule

// File: tb/mbox_port_test.sv
module mbox_port_test;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          h_sel = 0, h_wr = 0, h_rd = 0;
    logic [1:0]    h_reg = 0;
    logic [7:0]    h_wdata = 0;
    logic [7:0]    h_rdata;
    logic          host_irq;
    logic          cp_en = 0, cp_we = 0;
    logic [AW-1:0] cp_addr = 0;
    logic [7:0]    cp_wdata = 0;
    logic [7:0]    cp_rdata;
    logic          cp_set_int0 = 0, cp_set_int1 = 0, cp_db_ack = 0;
    logic          cp_run, cp_bypass, cp_doorbell;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    mbox_port #(.MEM_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_wr(h_wr), .h_rd(h_rd),
        .h_reg(h_reg), .h_wdata(h_wdata), .h_rdata(h_rdata), .host_irq(host_irq),
        .cp_en(cp_en), .cp_we(cp_we), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
        .cp_rdata(cp_rdata), .cp_set_int0(cp_set_int0), .cp_set_int1(cp_set_int1),
        .cp_db_ack(cp_db_ack), .cp_run(cp_run), .cp_bypass(cp_bypass),
        .cp_doorbell(cp_doorbell)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic hw(input logic [1:0] r, input logic [7:0] d);
        @(negedge clk);
        h_sel = 1; h_wr = 1; h_reg = r; h_wdata = d;
        @(negedge clk);
        h_sel = 0; h_wr = 0;
    endtask

    task automatic hr(input logic [1:0] r, output logic [7:0] d);
        @(negedge clk);
        h_sel = 1; h_rd = 1; h_reg = r;
        #2 d = h_rdata;
        @(negedge clk);
        h_sel = 0; h_rd = 0;
    endtask

    task automatic cpw(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        cp_en = 1; cp_we = 1; cp_addr = a; cp_wdata = d;
        @(negedge clk);
        cp_en = 0; cp_we = 0;
    endtask

    task automatic cpr(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        cp_en = 1; cp_addr = a;
        #2 d = cp_rdata;
        cp_en = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        hr(3, v); check("R1 status", v, 8'h00);
        hr(0, v); check("R1 ptr lo", v, 8'h00);
        hr(1, v); check("R1 ptr hi", v, 8'h00);
        check("R1 outputs", {host_irq, cp_run, cp_bypass, cp_doorbell}, 4'b0000);
    endtask

    task automatic t_pointer();
        logic [7:0] v;
        hw(0, 8'h34); hw(1, 8'h12);
        hr(0, v); check("R2 ptr lo", v, 8'h34);
        hr(1, v); check("R2 ptr hi", v, 8'h12);
        hr(0, v); check("R2 read keeps ptr", v, 8'h34);
    endtask

    task automatic t_data();
        logic [7:0] v;
        hw(0, 8'h05); hw(1, 8'h00);
        hw(2, 8'hA5);
        hr(2, v); check("R3 data readback", v, 8'hA5);
        hr(0, v); check("R4 no step when off", v, 8'h05);
        cpr(6'd5, v); check("R3 cp sees host byte", v, 8'hA5);
        cpw(6'h10, 8'hFF);
        hw(0, 8'h10);
        hr(2, v); check("R3 health byte", v, 8'hFF);
        hw(2, 8'h00);
        cpr(6'h10, v); check("R3 health cleared", v, 8'h00);
    endtask

    task automatic t_autoinc();
        logic [7:0] v;
        hw(3, 8'h03);
        check("R10 run on", cp_run, 1'b1);
        hw(0, 8'h20); hw(1, 8'h00);
        hw(2, 8'h11); hw(2, 8'h22); hw(2, 8'h33);
        hr(0, v); check("R4 write steps", v, 8'h23);
        hw(0, 8'h20);
        hr(2, v); check("R4 stream 0", v, 8'h11);
        hr(2, v); check("R4 stream 1", v, 8'h22);
        hr(2, v); check("R4 stream 2", v, 8'h33);
        hr(0, v); check("R4 read steps", v, 8'h23);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        hw(0, 8'hFF); hw(1, 8'hFF);
        hw(2, 8'h5A);
        hr(0, v); check("R5 wrap lo", v, 8'h00);
        hr(1, v); check("R5 wrap hi", v, 8'h00);
        cpr(6'd63, v); check("R5 top byte", v, 8'h5A);
    endtask

    task automatic t_doorbell();
        hw(3, 8'h07);
        check("R6 doorbell set", cp_doorbell, 1'b1);
        hw(3, 8'h03);
        check("R6 zero ignored", cp_doorbell, 1'b1);
        @(negedge clk); cp_db_ack = 1;
        @(negedge clk); cp_db_ack = 0;
        check("R6 ack clears", cp_doorbell, 1'b0);
    endtask

    task automatic t_ints();
        logic [7:0] v;
        @(negedge clk); cp_set_int0 = 1;
        @(negedge clk); cp_set_int0 = 0; cp_set_int1 = 1;
        @(negedge clk); cp_set_int1 = 0;
        hr(3, v); check("R7 both flags", v, 8'h33);
        check("R7 irq", host_irq, 1'b1);
        hw(3, 8'h13);
        hr(3, v); check("R8 clear int0 keep int1", v, 8'h23);
        check("R8 irq still", host_irq, 1'b1);
        hw(3, 8'h03);
        hr(3, v); check("R8 zero no effect", v, 8'h23);
        hw(3, 8'h23);
        hr(3, v); check("R8 clear int1", v, 8'h03);
        check("R7 irq low", host_irq, 1'b0);
    endtask

    task automatic t_conflict();
        logic [7:0] v;
        @(negedge clk);
        cp_set_int0 = 1; h_sel = 1; h_wr = 1; h_reg = 3; h_wdata = 8'h13;
        @(negedge clk);
        cp_set_int0 = 0; h_sel = 0; h_wr = 0;
        hr(3, v); check("R9 set wins", v, 8'h13);
    endtask

    task automatic t_run();
        logic [7:0] v;
        hw(3, 8'h00);
        check("R10 halt", cp_run, 1'b0);
        hr(3, v); check("R10 run bit reads 0", v, 8'h10);
        hw(3, 8'h13);
        check("R10 run again", cp_run, 1'b1);
    endtask

    task automatic t_bypass();
        logic [7:0] v;
        hw(3, 8'h87);
        hr(3, v); check("R11 init value", v, 8'h87);
        check("R11 pins", {cp_bypass, cp_run, cp_doorbell}, 3'b111);
        hw(3, 8'hFF);
        hr(3, v); check("R11 bits 3 6 read 0", v, 8'h87);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_pointer();
        t_data();
        t_autoinc();
        t_wrap();
        t_doorbell();
        t_ints();
        t_conflict();
        t_run();
        t_bypass();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule